// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Nonoverlap Timing

This block turns two or four logic-level channel inputs into the high-side and low-side gate enables of four half-bridge switch pairs (legs). When the block starts, it picks one of two leg mappings. In the first, the legs are paired into two differential H-bridges, so one input drives two legs in opposite phase. In the second, the four legs are independent single-ended outputs. In the single-ended mapping, a separate enable input can hold every low-side switch open. The loads are then driven by the high side alone.

Each time a leg's target level changes, the switch that was on is released at once. The opposite switch is enabled only after a nonoverlap interval. That interval is a parameter, counted in ticks of a timebase. The timebase is either the system clock or the rising edges of an external clock pin, chosen at start-up. Mute, a fault-shutdown request and reset all force every gate low. Channel inputs, the low-side enable, mute, fault and the external clock each pass through a two-flop synchronizer first.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: The clock-source pin and the channel-mode pin are captured on the first clock edge after rstN goes high. Later changes on these pins have no effect until the next reset.
- R2: With channel mode 0 (paired), after settling, leg A has hi=inA and lo=!inA, and leg B has hi=!inA and lo=inA. Legs C and D follow inC in the same way. Inputs B and D and the low-side enable input have no effect.
- R3: With channel mode 1 (single-ended), after settling, leg i has hi=chanIn[i] and lo=!chanIn[i], for i = 0..3 (bit 0 is leg A, bit 3 is leg D).
- R4: With channel mode 1, a 0 on the low-side enable input keeps all four lo gates at 0. A 1 allows them to switch normally.
- R5: The hi and lo gates of a leg are never both 1.
- R6: With the internal timebase, a level change on a channel input turns off the conducting switch of the affected leg on the third clock edge after the change. The opposite switch turns on exactly DEAD_CYCLES clock edges after that.
- R7: If a leg's target changes again during a nonoverlap interval, the interval restarts from the state with both switches off. The new switch turns on DEAD_CYCLES ticks after the latest change is seen.
- R8: While reset, mute or fault shutdown is active, every hi and lo gate is 0. After the request is released, the legs settle to their mapped levels again after a nonoverlap interval.
- R9: With clock-source 0, every clock cycle is a timebase tick. With clock-source 1, only synchronized rising edges of extClk are ticks, so no switch turns on while extClk is static.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgClkSrc | input | 1 | Timebase select, captured at start: 0 system clock, 1 extClk edges |
| cfgChanMode | input | 1 | Leg mapping, captured at start: 0 paired, 1 single-ended |
| chanIn | input | 4 | Channel inputs, bit 0 = A … bit 3 = D |
| lowSideEn | input | 1 | Low-side enable, used in single-ended mode only |
| extClk | input | 1 | External timebase clock |
| mute | input | 1 | Forces all gates off while high |
| faultShdn | input | 1 | Fault shutdown request, forces all gates off while high |
| hiGate | output | 4 | High-side gate enables, one per leg |
| loGate | output | 4 | Low-side gate enables, one per leg |

## Verification
The bench builds the block with DEAD_CYCLES = 3. This keeps each nonoverlap window short enough to sweep every input combination in both mappings: 4 patterns in paired mode, and 16 patterns in single-ended mode, with the low-side enable at both values. The gap between the release of one switch and the enable of the other is measured to the exact cycle. This covers a single edge and an edge that arrives mid-interval. With the external timebase, the pin is first held static, which shows that no switch can turn on without ticks. It is then toggled slowly so that the legs settle.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef struct packed {
    logic tick;
    logic forceOff;
    logic fourChan;
    logic loAllow;
  } strobe_t;

  typedef enum logic [1:0] {
    LEG_DEAD = 2'd0,
    LEG_HI   = 2'd1,
    LEG_LO   = 2'd2
  } leg_state_e;
endpackage

// File: rtl/bgc_ctrl.sv
module bgc_ctrl
  import bgc_pkg::*;
#(
  parameter int NUM_LEGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgClkSrc,
  input  logic                cfgChanMode,
  input  logic [NUM_LEGS-1:0] chanIn,
  input  logic                lowSideEn,
  input  logic                extClk,
  input  logic                mute,
  input  logic                faultShdn,
  output logic [NUM_LEGS-1:0] chanSync,
  output strobe_t             stb
);
  localparam int SYNC_W = NUM_LEGS + 4;

  logic [SYNC_W-1:0] syncRaw;
  logic [SYNC_W-1:0] syncOut;
  logic [SYNC_W-1:0] syncChain [SYNC_STAGES];

  assign syncRaw = {extClk, faultShdn, mute, lowSideEn, chanIn};

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= syncRaw;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];

  logic started;
  logic clkSrcReg;
  logic chanModeReg;
  logic extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started     <= 1'b0;
      clkSrcReg   <= 1'b0;
      chanModeReg <= 1'b0;
    end else if (!started) begin
      started     <= 1'b1;
      clkSrcReg   <= cfgClkSrc;
      chanModeReg <= cfgChanMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else extPrev <= syncOut[NUM_LEGS+3];
  end

  logic extRise;
  assign extRise = syncOut[NUM_LEGS+3] & ~extPrev;

  always_comb begin
    chanSync     = syncOut[NUM_LEGS-1:0];
    stb.tick     = clkSrcReg ? extRise : 1'b1;
    stb.forceOff = ~started | syncOut[NUM_LEGS+1] | syncOut[NUM_LEGS+2];
    stb.fourChan = chanModeReg;
    stb.loAllow  = chanModeReg ? syncOut[NUM_LEGS] : 1'b1;
  end

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(started) |-> ($stable(chanModeReg) && $stable(clkSrcReg)));

  // R9
  int_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !clkSrcReg) |-> stb.tick);
endmodule

// File: rtl/bgc_legs.sv
module bgc_legs
  import bgc_pkg::*;
#(
  parameter int NUM_LEGS    = 4,
  parameter int DEAD_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [NUM_LEGS-1:0] chanSync,
  output logic [NUM_LEGS-1:0] hiGate,
  output logic [NUM_LEGS-1:0] loGate
);
  localparam int CNT_W = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEAD_CYCLES - 1);
  localparam int RUN_W = $clog2(DEAD_CYCLES + 1) + 1;

  logic [NUM_LEGS-1:0] target;

  always_comb begin
    for (int i = 0; i < NUM_LEGS; i++) begin
      if (stb.fourChan) target[i] = chanSync[i];
      else if (i % 2 == 0) target[i] = chanSync[i];
      else target[i] = ~chanSync[(i % 2 == 0) ? i : i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LEGS; g++) begin : g_leg
      leg_state_e      state;
      logic            pend;
      logic [CNT_W-1:0] cnt;
      logic [RUN_W-1:0] offRun;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          state <= LEG_DEAD;
          pend  <= 1'b0;
          cnt   <= '0;
        end else if (stb.forceOff) begin
          state <= LEG_DEAD;
          pend  <= target[g];
          cnt   <= '0;
        end else begin
          case (state)
            LEG_HI: if (!target[g]) begin
              state <= LEG_DEAD; pend <= 1'b0; cnt <= '0;
            end
            LEG_LO: if (target[g]) begin
              state <= LEG_DEAD; pend <= 1'b1; cnt <= '0;
            end
            default: begin
              if (target[g] != pend) begin
                pend <= target[g];
                cnt  <= '0;
              end else if (stb.tick) begin
                if (cnt == CNT_LAST) state <= pend ? LEG_HI : LEG_LO;
                else cnt <= cnt + 1'b1;
              end
            end
          endcase
        end
      end

      assign hiGate[g] = (state == LEG_HI) & ~stb.forceOff;
      assign loGate[g] = (state == LEG_LO) & ~stb.forceOff & stb.loAllow;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) offRun <= '0;
        else if (hiGate[g] | loGate[g]) offRun <= '0;
        else if (offRun < RUN_W'(DEAD_CYCLES)) offRun <= offRun + 1'b1;
      end

      // R5
      no_shoot_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(hiGate[g] && loGate[g]));

      // R6
      hi_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(hiGate[g]) |-> (offRun >= RUN_W'(DEAD_CYCLES)));

      // R6
      lo_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(loGate[g]) && $past(state) != LEG_LO) |-> (offRun >= RUN_W'(DEAD_CYCLES)));
    end
  endgenerate

  // R4
  lo_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fourChan && !stb.loAllow) |-> (loGate == '0));

  // R8
  force_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceOff |-> (hiGate == '0 && loGate == '0));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgClkSrc,
  input  logic       cfgChanMode,
  input  logic [3:0] chanIn,
  input  logic       lowSideEn,
  input  logic       extClk,
  input  logic       mute,
  input  logic       faultShdn,
  output logic [3:0] hiGate,
  output logic [3:0] loGate
);
  localparam int NUM_LEGS = 4;

  strobe_t             stb;
  logic [NUM_LEGS-1:0] chanSync;

  bgc_ctrl #(.NUM_LEGS(NUM_LEGS), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgClkSrc(cfgClkSrc), .cfgChanMode(cfgChanMode),
    .chanIn(chanIn), .lowSideEn(lowSideEn), .extClk(extClk), .mute(mute),
    .faultShdn(faultShdn), .chanSync(chanSync), .stb(stb)
  );

  bgc_legs #(.NUM_LEGS(NUM_LEGS), .DEAD_CYCLES(DEAD_CYCLES)) u_legs (
    .clk(clk), .rstN(rstN), .stb(stb), .chanSync(chanSync),
    .hiGate(hiGate), .loGate(loGate)
  );
endmodule

// File: tb/bridge_gate_ctrl_test.sv
module bridge_gate_ctrl_test;
  localparam int DT = 3;

  logic clk = 0;
  logic rstN = 0;
  logic cfgClkSrc = 0, cfgChanMode = 0;
  logic [3:0] chanIn = 0;
  logic lowSideEn = 1, extClk = 0, mute = 0, faultShdn = 0;
  logic [3:0] hiGate, loGate;

  int nChk = 0, nBad = 0;

  always #2 clk = ~clk;

  bridge_gate_ctrl #(.DEAD_CYCLES(DT)) uut (
    .clk(clk), .rstN(rstN), .cfgClkSrc(cfgClkSrc), .cfgChanMode(cfgChanMode),
    .chanIn(chanIn), .lowSideEn(lowSideEn), .extClk(extClk), .mute(mute),
    .faultShdn(faultShdn), .hiGate(hiGate), .loGate(loGate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R5: overlap monitor
  always @(negedge clk) if (rstN && ((hiGate & loGate) != 0)) begin
    nChk++; nBad++;
    $display("FAIL R5 actual=%0h expected=0", hiGate & loGate);
  end

  task automatic doReset(input logic src, input logic md);
    @(negedge clk);
    rstN = 0; cfgClkSrc = src; cfgChanMode = md;
    cyc(3);
    check(hiGate == 0 && loGate == 0, "R8 reset", {hiGate, loGate}, 0);
    rstN = 1;
    cyc(1);
    cfgClkSrc = ~src; cfgChanMode = ~md;  // R1: later pin changes ignored
  endtask

  function automatic logic [7:0] expPaired(input logic [3:0] in);
    logic [3:0] h;
    h = {~in[2], in[2], ~in[0], in[0]};
    return {h, ~h};
  endfunction

  initial begin
    int offK, onK;
    #400000;
    nChk++; nBad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int offK, onK;
    // paired mode, internal timebase
    doReset(0, 0);
    for (int p = 0; p < 16; p++) begin
      chanIn = 4'(p); lowSideEn = p[0];
      cyc(12);
      // R2 (inputs B/D and low-side enable ignored), R1
      check({hiGate, loGate} == expPaired(4'(p)), "R2", {hiGate, loGate}, expPaired(4'(p)));
    end
    // R6: exact timing, leg A hi->lo and leg B lo->hi
    chanIn = 4'b0001; cyc(12);
    chanIn = 4'b0000;
    offK = -1; onK = -1;
    for (int k = 1; k < 30; k++) begin
      @(negedge clk);
      if (offK < 0 && !hiGate[0] && loGate[1] == 0) offK = k;
      if (onK < 0 && loGate[0] && hiGate[1]) onK = k;
    end
    check(offK == 3, "R6 off", offK, 3);
    check(onK == 3 + DT, "R6 on", onK, 3 + DT);
    // R7: glitch during nonoverlap restarts interval
    chanIn = 4'b0001; cyc(12);
    @(negedge clk); chanIn = 4'b0000;
    @(negedge clk); chanIn = 4'b0001;
    offK = -1; onK = -1;
    for (int k = 2; k < 30; k++) begin
      @(negedge clk);
      if (loGate[0]) onK = 99;
      if (offK < 0 && !hiGate[0]) offK = k;
      if (offK >= 0 && onK < 0 && hiGate[0]) onK = k;
    end
    check(offK == 3, "R7 off", offK, 3);
    check(onK == 4 + DT, "R7 restart", onK, 4 + DT);
    // R8: mute and fault
    mute = 1; cyc(4);
    check(hiGate == 0 && loGate == 0, "R8 mute", {hiGate, loGate}, 0);
    mute = 0; cyc(12);
    check({hiGate, loGate} == expPaired(4'b0001), "R8 mute release", {hiGate, loGate}, expPaired(4'b0001));
    faultShdn = 1; cyc(4);
    check(hiGate == 0 && loGate == 0, "R8 fault", {hiGate, loGate}, 0);
    faultShdn = 0; cyc(12);
    check({hiGate, loGate} == expPaired(4'b0001), "R8 fault release", {hiGate, loGate}, expPaired(4'b0001));

    // single-ended mode
    doReset(0, 1);
    for (int p = 0; p < 32; p++) begin
      chanIn = 4'(p); lowSideEn = p[4];
      cyc(12);
      check(hiGate == 4'(p), "R3 hi", hiGate, 4'(p));
      if (p[4]) check(loGate == ~4'(p), "R3 lo", loGate, ~4'(p));
      else check(loGate == 0, "R4 lo disabled", loGate, 0);
    end

    // R9: external timebase
    lowSideEn = 1; chanIn = 4'b0101;
    doReset(1, 1);
    chanIn = 4'b0101;
    cyc(40);
    check(hiGate == 0 && loGate == 0, "R9 static ext", {hiGate, loGate}, 0);
    for (int t = 0; t < 2 * DT + 4; t++) begin
      extClk = ~extClk; cyc(4);
    end
    cyc(6);
    check(hiGate == 4'b0101 && loGate == 4'b1010, "R9 ext ticks", {hiGate, loGate}, 8'h5a);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule